// File: doc/BRIEF.md
# Floating-Point Status Word and Exception Trap Unit

This block keeps the 32-bit status and control word of a floating-point unit. From that word it drives the datapath controls: a one-hot rounding-mode select, and one flush-to-zero control that covers both input operands and results. The arithmetic units are outside the block. When an operation completes, the unit that ran it pulses `op_done` and presents five raw exception flags.

The block first places the raw flags at the positions of their enable bits. It checks that vector against the enables to decide whether to request a trap. It then shifts the vector by a fixed amount into the sticky-flag field and ORs it into the word. Sticky flags stay set until software clears them by writing the word. The trap decision uses only the exceptions that the current operation raised, so flags left over from earlier operations never cause a trap. Software can overwrite the whole word at any time. If a write and an operation completion fall in the same cycle, the write wins and the operation's exceptions are discarded.

Top module: `fp_status_trap`

## Requirements
- R1: After reset the word reads 0, `rm_onehot` is 4'b0001, `ftz` is 0 and `trap` is 0.
- R2: The rounding field is word bits [10:9]. Value 0 gives `rm_onehot` 4'b0001 (nearest-even), 1 gives 4'b0010 (toward zero), 2 gives 4'b0100 (toward +infinity) and 3 gives 4'b1000 (toward −infinity).
- R3: `ftz` equals word bit 5, the denormal-handling bit. This one bit controls flushing of both operands and results.
- R4: When `sw_we` is high, the whole word becomes `sw_wdata` on the next clock edge, and `status_out` shows it from then on.
- R5: An `op_done` with `exc_in` equal to 0 leaves the word unchanged and raises no trap.
- R6: `exc_in` bit order is inexact [0], underflow [1], overflow [2], divide-by-zero [3] and invalid [4]. These map to enable bits I=0, U=1, O=2, Z=3, V=4 and to sticky flags at bits 27 to 31 in the same order. After an `op_done`, every raised flag is ORed into its sticky bit, and all other bits of the word are kept.
- R7: `trap` is high for exactly the one cycle after an `op_done` whose `exc_in` ANDed with the enables (word bits [4:0]) is nonzero. Sticky flags that are already set do not count toward this test.
- R8: If `sw_we` and `op_done` are high in the same cycle, the write takes effect, the exception merge is dropped and no trap is raised.
- R9: While `op_done` is low, `exc_in` has no effect on the word or on `trap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_done | input | 1 | One-cycle strobe marking the end of an FP operation |
| exc_in | input | 5 | Raw exception flags of the finished operation |
| sw_we | input | 1 | Software write enable for the whole word |
| sw_wdata | input | 32 | Software write data |
| status_out | output | 32 | Current status/control word |
| rm_onehot | output | 4 | One-hot rounding-mode control |
| ftz | output | 1 | Flush-to-zero for operands and results |
| trap | output | 1 | Trap request pulse, one cycle after `op_done` |

## Verification
The bench sets up cases where an enabled exception was raised earlier and is still sticky, while the current operation raises only disabled ones. A design that judged the trap against the accumulated flags would trap falsely in those cases. It also drives a software write and an exception-carrying completion in the same cycle. A design with the wrong priority would let flags leak into the newly written word or raise a spurious trap. It also applies exceptions without the strobe, and follows each trap with an idle cycle. These cases catch a design that merges flags without the strobe, and one whose trap stays high for more than one cycle.

// File: rtl/fpst_pkg.sv
package fpst_pkg;

    // Default word geometry; the top module may override through parameters.
    localparam int unsigned FPST_WORD_W     = 32;
    localparam int unsigned FPST_NEXC       = 5;
    localparam int unsigned FPST_ENA_LSB    = 0;
    localparam int unsigned FPST_FLAG_LSB   = 27;
    localparam int unsigned FPST_DENORM_BIT = 5;
    localparam int unsigned FPST_RM_LSB     = 9;
    localparam int unsigned FPST_RM_W       = 2;

    // Rounding-mode encodings of the 2-bit field.
    typedef enum logic [1:0] {
        RND_NEAREST_EVEN = 2'd0,
        RND_TOWARD_ZERO  = 2'd1,
        RND_TOWARD_POS   = 2'd2,
        RND_TOWARD_NEG   = 2'd3
    } fpst_rnd_e;

    // Index of each exception inside exc_in and inside the enable field.
    localparam int unsigned EXC_INEXACT  = 0;
    localparam int unsigned EXC_UNDER    = 1;
    localparam int unsigned EXC_OVER     = 2;
    localparam int unsigned EXC_DIVZERO  = 3;
    localparam int unsigned EXC_INVALID  = 4;

endpackage

// File: rtl/fpst_rm_decode.sv
module fpst_rm_decode #(
    parameter int unsigned RM_W = 2,
    localparam int unsigned RM_N = 1 << RM_W
) (
    input  logic [RM_W-1:0] rm_field,
    output logic [RM_N-1:0] rm_onehot
);

    // One select line per field value (R2).
    for (genvar i = 0; i < RM_N; i++) begin : g_sel
        assign rm_onehot[i] = (rm_field == RM_W'(i));
    end

endmodule

// File: rtl/fpst_exc_map.sv
module fpst_exc_map #(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned NEXC     = 5,
    parameter int unsigned ENA_LSB  = 0,
    parameter int unsigned FLAG_LSB = 27,
    localparam int unsigned SHIFT   = FLAG_LSB - ENA_LSB
) (
    input  logic [NEXC-1:0]   exc_raw,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] flag_or,
    output logic              enabled_hit
);

    logic [WORD_W-1:0] at_enable;

    // Raw flags are first placed at the positions of their enable bits.
    always_comb begin
        at_enable = '0;
        for (int k = 0; k < int'(NEXC); k++) begin
            at_enable[ENA_LSB + k] = exc_raw[k];
        end
    end

    // Trap decision uses only the newly raised vector (R7).
    assign enabled_hit = |(at_enable & word);

    // A fixed shift moves the vector into the sticky-flag field (R6).
    assign flag_or = at_enable << SHIFT;

endmodule

// File: rtl/fp_status_trap.sv
module fp_status_trap
    import fpst_pkg::*;
#(
    parameter int unsigned WORD_W     = FPST_WORD_W,
    parameter int unsigned NEXC       = FPST_NEXC,
    parameter int unsigned ENA_LSB    = FPST_ENA_LSB,
    parameter int unsigned FLAG_LSB   = FPST_FLAG_LSB,
    parameter int unsigned DENORM_BIT = FPST_DENORM_BIT,
    parameter int unsigned RM_LSB     = FPST_RM_LSB,
    parameter int unsigned RM_W       = FPST_RM_W,
    localparam int unsigned RM_N      = 1 << RM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_done,
    input  logic [NEXC-1:0]   exc_in,
    input  logic              sw_we,
    input  logic [WORD_W-1:0] sw_wdata,
    output logic [WORD_W-1:0] status_out,
    output logic [RM_N-1:0]   rm_onehot,
    output logic              ftz,
    output logic              trap
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              trap;
    } state_t;

    state_t st_d, st_q;

    logic [WORD_W-1:0] flag_or;
    logic              enabled_hit;

    fpst_exc_map #(
        .WORD_W   (WORD_W),
        .NEXC     (NEXC),
        .ENA_LSB  (ENA_LSB),
        .FLAG_LSB (FLAG_LSB)
    ) u_exc_map (
        .exc_raw     (exc_in),
        .word        (st_q.word),
        .flag_or     (flag_or),
        .enabled_hit (enabled_hit)
    );

    fpst_rm_decode #(
        .RM_W (RM_W)
    ) u_rm_decode (
        .rm_field  (st_q.word[RM_LSB +: RM_W]),
        .rm_onehot (rm_onehot)
    );

    // Next-state: software write wins over the exception merge (R8).
    always_comb begin
        st_d      = st_q;
        st_d.trap = 1'b0;
        if (sw_we) begin
            st_d.word = sw_wdata;
        end else if (op_done) begin
            st_d.word = st_q.word | flag_or;
            st_d.trap = enabled_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_out = st_q.word;
    assign ftz        = st_q.word[DENORM_BIT];
    assign trap       = st_q.trap;

endmodule

// File: rtl/fpst_checker.sv
module fpst_checker #(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned NEXC       = 5,
    parameter int unsigned ENA_LSB    = 0,
    parameter int unsigned FLAG_LSB   = 27,
    parameter int unsigned DENORM_BIT = 5,
    parameter int unsigned RM_N       = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_done,
    input logic [NEXC-1:0]   exc_in,
    input logic              sw_we,
    input logic [WORD_W-1:0] sw_wdata,
    input logic [WORD_W-1:0] status_out,
    input logic [RM_N-1:0]   rm_onehot,
    input logic              ftz,
    input logic              trap
);

    // R2
    rm_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rm_onehot) == 1);

    // R3
    ftz_follows_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ftz == status_out[DENORM_BIT]);

    // R4 R8
    sw_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (status_out == $past(sw_wdata)) && !trap);

    // R5
    quiet_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !sw_we && exc_in == '0) |=> $stable(status_out) && !trap);

    // R6
    sticky_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !sw_we) |=>
            status_out[FLAG_LSB +: NEXC] ==
            ($past(status_out[FLAG_LSB +: NEXC]) | $past(exc_in)));

    // R7
    trap_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !sw_we && |(exc_in & status_out[ENA_LSB +: NEXC])) |=> trap);

    // R7
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> $past(op_done) && !$past(sw_we));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_done && !sw_we) |=> $stable(status_out) && !trap);

endmodule

bind fp_status_trap fpst_checker #(
    .WORD_W     (WORD_W),
    .NEXC       (NEXC),
    .ENA_LSB    (ENA_LSB),
    .FLAG_LSB   (FLAG_LSB),
    .DENORM_BIT (DENORM_BIT),
    .RM_N       (RM_N)
) u_fpst_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_done    (op_done),
    .exc_in     (exc_in),
    .sw_we      (sw_we),
    .sw_wdata   (sw_wdata),
    .status_out (status_out),
    .rm_onehot  (rm_onehot),
    .ftz        (ftz),
    .trap       (trap)
);

// File: tb/fp_status_trap_bench.sv
`timescale 1ns/1ps
module fp_status_trap_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_done = 1'b0;
    logic [4:0]  exc_in = '0;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] status_out;
    logic [3:0]  rm_onehot;
    logic        ftz;
    logic        trap;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [31:0] exp_word = '0;
    logic        exp_trap = 1'b0;

    always #4 clk = ~clk;

    fp_status_trap u_fp_status_trap (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_done    (op_done),
        .exc_in     (exc_in),
        .sw_we      (sw_we),
        .sw_wdata   (sw_wdata),
        .status_out (status_out),
        .rm_onehot  (rm_onehot),
        .ftz        (ftz),
        .trap       (trap)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare every output against the bench model.
    task automatic chk_all(input string req);
        chk(req, "status_out", status_out, exp_word);
        chk(req, "trap", {31'b0, trap}, {31'b0, exp_trap});
        chk(req, "rm_onehot", {28'b0, rm_onehot}, {28'b0, 4'b0001 << exp_word[10:9]});
        chk(req, "ftz", {31'b0, ftz}, {31'b0, exp_word[5]});
    endtask

    // One cycle of stimulus, driven at a falling edge, model updated per requirements.
    task automatic cycle(input logic op, input logic [4:0] exc,
                         input logic we, input logic [31:0] wd);
        op_done = op; exc_in = exc; sw_we = we; sw_wdata = wd;
        @(negedge clk);
        if (we) begin
            exp_word = wd;
            exp_trap = 1'b0;
        end else if (op) begin
            exp_trap = |(exc & exp_word[4:0]);
            exp_word = exp_word | ({27'b0, exc} << 27);
        end else begin
            exp_trap = 1'b0;
        end
        op_done = 1'b0; exc_in = '0; sw_we = 1'b0; sw_wdata = '0;
    endtask

    task automatic t_reset;
        exp_word = '0; exp_trap = 1'b0;
        chk_all("R1");
    endtask

    task automatic t_rounding;
        for (int m = 0; m < 4; m++) begin
            cycle(1'b0, '0, 1'b1, 32'(m) << 9);
            chk_all("R2");
        end
    endtask

    task automatic t_flush;
        cycle(1'b0, '0, 1'b1, 32'h0000_0020);
        chk_all("R3");
        cycle(1'b0, '0, 1'b1, 32'h0000_0000);
        chk_all("R3");
    endtask

    task automatic t_software_write;
        cycle(1'b0, '0, 1'b1, 32'hA5A5_0F0F);
        chk_all("R4");
        cycle(1'b0, '0, 1'b1, 32'h0000_0000);
        chk_all("R4");
    endtask

    task automatic t_quiet_op;
        cycle(1'b0, '0, 1'b1, 32'h0000_021F);
        cycle(1'b1, 5'b00000, 1'b0, '0);
        chk_all("R5");
    endtask

    task automatic t_sticky;
        cycle(1'b0, '0, 1'b1, 32'h0000_0400);
        cycle(1'b1, 5'b00001, 1'b0, '0);      // inexact -> bit 27
        chk_all("R6");
        cycle(1'b1, 5'b10000, 1'b0, '0);      // invalid -> bit 31, 27 stays
        chk_all("R6");
        cycle(1'b1, 5'b01110, 1'b0, '0);
        chk("R6", "flags", status_out, 32'hF800_0400);
    endtask

    task automatic t_trap;
        cycle(1'b0, '0, 1'b1, 32'h0000_0002); // only underflow enabled
        cycle(1'b1, 5'b00001, 1'b0, '0);      // inexact: disabled
        chk_all("R7");
        cycle(1'b1, 5'b00011, 1'b0, '0);      // underflow raised
        chk_all("R7");
        chk("R7", "trap raised", {31'b0, trap}, 32'h1);
        cycle(1'b0, '0, 1'b0, '0);            // pulse lasts one cycle
        chk_all("R7");
    endtask

    task automatic t_new_only;
        cycle(1'b0, '0, 1'b1, 32'h8000_0010); // invalid sticky and enabled
        cycle(1'b1, 5'b00001, 1'b0, '0);
        chk("R7", "stale flag no trap", {31'b0, trap}, 32'h0);
        chk_all("R7");
    endtask

    task automatic t_collision;
        cycle(1'b0, '0, 1'b1, 32'h0000_001F);
        cycle(1'b1, 5'b11111, 1'b1, 32'h0000_005F);
        chk_all("R8");
        chk("R8", "write kept", status_out, 32'h0000_005F);
    endtask

    task automatic t_no_strobe;
        cycle(1'b0, '0, 1'b1, 32'h0000_001F);
        cycle(1'b0, 5'b11111, 1'b0, '0);
        chk_all("R9");
        chk("R9", "word untouched", status_out, 32'h0000_001F);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_rounding;
        t_flush;
        t_software_write;
        t_quiet_op;
        t_sticky;
        t_trap;
        t_new_only;
        t_collision;
        t_no_strobe;
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end

endmodule